// File: doc/BRIEF.md
# Per-Thread Interrupt Presenter

This block is the interrupt presenter for one processor thread. Software reaches it through a 4 KiB register window, using accesses of 1, 2 or 4 bytes. The block holds the thread's current processor priority, a single pending interrupt (source number and priority) and an inter-processor-interrupt (IPI) priority. From that state it drives an interrupt line toward the processor.

A source controller outside the block offers interrupts on a one-cycle "source presented" input. The presenter keeps an offer only when it is more favoured than both the current priority and any interrupt already pending. Software takes the interrupt with a word read of the accept register. That read returns the interrupt word and raises the current priority to the priority of the interrupt it took. Software finishes the interrupt with a word write to the same register, which sends an end-of-interrupt pulse back to the source controller. Each register accepts only the access widths listed for it. Any other access is flagged and has no effect on the block's state.

Top module: `ipr_top`

## Requirements
- R1: After reset the current priority is 0x00, the IPI priority is 0xFF, nothing is pending, all link registers hold 0, `irq_out` is low and `eoi_valid` is low.
- R2: A 4-byte read at offset 0x0 returns the interrupt word and changes no state. The interrupt word carries the current priority in bits [31:24]. Bits [23:0] hold the pending source number while `irq_out` is high, and 0 otherwise.
- R3: A 1-byte read with address bits [1:0] = 00 at offset 0x0 or 0x4 returns the current priority in bits [7:0], with bits [31:8] zero. Byte data always travels in bits [7:0] of the data buses.
- R4: A 4-byte read at offset 0x4 returns the interrupt word. If `irq_out` was high, the read also loads the current priority with the pending priority, clears the pending interrupt and drops `irq_out`. If `irq_out` was low, the read changes nothing.
- R5: A 1-byte write with address bits [1:0] = 00 at offset 0x4 sets the current priority. A lower value is more favoured. `irq_out` is high exactly when an interrupt is pending and its priority is numerically lower than the current priority, so a masked pending interrupt stays stored.
- R6: A 4-byte write at offset 0x4 loads the current priority from bits [31:24] of the written word. One cycle later it pulses `eoi_valid` for one cycle, with `eoi_source` equal to bits [23:0] of the written word.
- R7: The IPI priority register at offset 0xC is read and written only as a 1-byte access with address bits [1:0] = 00. A write whose value would be accepted under the R10 rule makes source number `IPI_SRC` (default 2) pending at that priority.
- R8: `N_LINKS` link registers at offsets 0x10, 0x14, 0x18 … are plain 32-bit storage, read and written only as 4-byte accesses.
- R9: Every other access is illegal: wrong width, a byte outside lane 0, or an unmapped offset. An illegal read returns 0xFFFFFFFF. An illegal write changes no state and raises no end-of-interrupt. Every illegal access pulses `bad_access` together with its response.
- R10: An offer on `src_valid` is kept only when its priority is numerically lower than the current priority and, if an interrupt is already pending, also lower than the pending priority. A kept offer replaces the pending interrupt. Any other offer is dropped. When a register access and an offer land in the same cycle, the access is applied first.
- R11: Each access gets exactly one response cycle (`rsp_valid`), one clock after the request cycle. There is no response without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_size | input | 3 | Access width in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data; byte writes use bits [7:0] |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data; byte reads return bits [7:0] |
| bad_access | output | 1 | Pulses with the response of an illegal access |
| src_valid | input | 1 | A source offers an interrupt this cycle |
| src_num | input | 24 | Offered source number |
| src_prio | input | 8 | Offered priority (lower is more favoured) |
| irq_out | output | 1 | Interrupt request toward the processor |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_source | output | 24 | Source number carried by the end-of-interrupt |

## Verification
The bench builds the block with its defaults: `N_LINKS` = 3 and `IPI_SRC` = 2. With three links, every mapped slot (0x0, 0x4, 0xC, 0x10–0x18) is covered, and so is the first unmapped slot after the link bank (0x1C). The IPI source number 2 is distinct from the externally offered sources, so the interrupt word shows which path made an interrupt pending. The bench also runs the cases where priority order decides the outcome: an offer equal to the current priority, a less favoured offer against a pending one, and masking by a raised priority followed by unmasking.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;
    localparam int ADDR_W = 12;
    localparam int SLOT_W = ADDR_W - 2;

    localparam logic [SLOT_W-1:0] SLOT_POLL  = SLOT_W'(0);
    localparam logic [SLOT_W-1:0] SLOT_XIRR  = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] SLOT_IPI   = SLOT_W'(3);
    localparam int                SLOT_LINK0 = 4;

    localparam logic [2:0] SIZE_BYTE = 3'd1;
    localparam logic [2:0] SIZE_WORD = 3'd4;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_POLL_WORD,
        OP_PRIO_READ,
        OP_ACCEPT,
        OP_SET_PRIO,
        OP_EOI,
        OP_IPI_READ,
        OP_IPI_WRITE,
        OP_LINK_READ,
        OP_LINK_WRITE,
        OP_BAD
    } op_e;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [SRC_W-1:0]  src;
    } pend_t;

    // Lower numeric value wins.
    function automatic logic favoured(input logic [PRIO_W-1:0] a,
                                      input logic [PRIO_W-1:0] b);
        return a < b;
    endfunction

    // Would a candidate priority displace the pending entry under the current priority?
    function automatic logic can_take(input pend_t             cur,
                                      input logic [PRIO_W-1:0] cand,
                                      input logic [PRIO_W-1:0] cppr);
        return favoured(cand, cppr) && (!cur.valid || favoured(cand, cur.prio));
    endfunction

endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
    import ipr_pkg::*;
#(
    parameter int N_LINKS = 3
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    output op_e               op,
    output logic [SLOT_W-1:0] slot
);
    localparam int LINK_END = SLOT_LINK0 + N_LINKS;

    logic lane0;
    logic word;
    logic link_hit;

    always_comb begin
        slot     = req_addr[ADDR_W-1:2];
        lane0    = (req_size == SIZE_BYTE) && (req_addr[1:0] == 2'b00);
        word     = (req_size == SIZE_WORD);
        link_hit = (int'(slot) >= SLOT_LINK0) && (int'(slot) < LINK_END);
        op       = OP_NONE;
        if (req_valid) begin
            op = OP_BAD;
            if (link_hit) begin
                if (word) op = req_write ? OP_LINK_WRITE : OP_LINK_READ;
            end else begin
                case (slot)
                    SLOT_POLL: begin
                        if (!req_write) begin
                            if (word)       op = OP_POLL_WORD;
                            else if (lane0) op = OP_PRIO_READ;
                        end
                    end
                    SLOT_XIRR: begin
                        if (req_write) begin
                            if (word)       op = OP_EOI;
                            else if (lane0) op = OP_SET_PRIO;
                        end else begin
                            if (word)       op = OP_ACCEPT;
                            else if (lane0) op = OP_PRIO_READ;
                        end
                    end
                    SLOT_IPI: begin
                        if (lane0) op = req_write ? OP_IPI_WRITE : OP_IPI_READ;
                    end
                    default: op = OP_BAD;
                endcase
            end
        end
    end

endmodule

// File: rtl/ipr_core.sv
module ipr_core
    import ipr_pkg::*;
#(
    parameter logic [SRC_W-1:0] IPI_SRC = SRC_W'(2)
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [WORD_W-1:0] wdata,
    input  logic              src_valid,
    input  logic [SRC_W-1:0]  src_num,
    input  logic [PRIO_W-1:0] src_prio,
    output logic [PRIO_W-1:0] cppr,
    output logic [PRIO_W-1:0] ipi_prio,
    output pend_t             pend,
    output logic              irq_out,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_source
);
    logic [PRIO_W-1:0] cppr_n;
    logic [PRIO_W-1:0] ipi_n;
    pend_t             pend_n;
    logic [PRIO_W-1:0] wbyte;

    assign wbyte   = wdata[PRIO_W-1:0];
    assign irq_out = pend.valid && favoured(pend.prio, cppr);

    always_comb begin
        cppr_n = cppr;
        ipi_n  = ipi_prio;
        pend_n = pend;
        case (op)
            OP_ACCEPT: begin
                if (irq_out) begin
                    cppr_n = pend.prio;
                    pend_n = '0;
                end
            end
            OP_SET_PRIO: cppr_n = wbyte;
            OP_EOI:      cppr_n = wdata[WORD_W-1 -: PRIO_W];
            OP_IPI_WRITE: begin
                ipi_n = wbyte;
                if (can_take(pend_n, wbyte, cppr_n)) begin
                    pend_n.valid = 1'b1;
                    pend_n.prio  = wbyte;
                    pend_n.src   = IPI_SRC;
                end
            end
            default: ;
        endcase
        // Register access is applied before an offer from the source side.
        if (src_valid && can_take(pend_n, src_prio, cppr_n)) begin
            pend_n.valid = 1'b1;
            pend_n.prio  = src_prio;
            pend_n.src   = src_num;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cppr       <= '0;
            ipi_prio   <= '1;
            pend       <= '0;
            eoi_valid  <= 1'b0;
            eoi_source <= '0;
        end else begin
            cppr      <= cppr_n;
            ipi_prio  <= ipi_n;
            pend      <= pend_n;
            eoi_valid <= (op == OP_EOI);
            if (op == OP_EOI) eoi_source <= wdata[SRC_W-1:0];
        end
    end

endmodule

// File: rtl/ipr_links.sv
module ipr_links
    import ipr_pkg::*;
#(
    parameter int N_LINKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [N_LINKS-1:0][WORD_W-1:0] bank;

    for (genvar g = 0; g < N_LINKS; g++) begin : g_link
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(SLOT_LINK0 + g);
        logic [WORD_W-1:0] store_q;
        always_ff @(posedge clk) begin
            if (rst)                           store_q <= '0;
            else if (wr_en && slot == MY_SLOT) store_q <= wdata;
        end
        assign bank[g] = store_q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_LINKS; i++) begin
            if (slot == SLOT_W'(SLOT_LINK0 + i)) rdata = bank[i];
        end
    end

endmodule

// File: rtl/ipr_top.sv
module ipr_top
    import ipr_pkg::*;
#(
    parameter int               N_LINKS = 3,
    parameter logic [SRC_W-1:0] IPI_SRC = SRC_W'(2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              bad_access,
    input  logic              src_valid,
    input  logic [SRC_W-1:0]  src_num,
    input  logic [PRIO_W-1:0] src_prio,
    output logic              irq_out,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_source
);
    op_e               op;
    logic [SLOT_W-1:0] slot;
    logic [PRIO_W-1:0] cppr;
    logic [PRIO_W-1:0] ipi_prio;
    pend_t             pend;
    logic [WORD_W-1:0] link_rd;
    logic [WORD_W-1:0] xirr_word;
    logic [WORD_W-1:0] rd_mux;

    ipr_decode #(.N_LINKS(N_LINKS)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .op        (op),
        .slot      (slot)
    );

    ipr_core #(.IPI_SRC(IPI_SRC)) u_core (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .wdata      (req_wdata),
        .src_valid  (src_valid),
        .src_num    (src_num),
        .src_prio   (src_prio),
        .cppr       (cppr),
        .ipi_prio   (ipi_prio),
        .pend       (pend),
        .irq_out    (irq_out),
        .eoi_valid  (eoi_valid),
        .eoi_source (eoi_source)
    );

    ipr_links #(.N_LINKS(N_LINKS)) u_links (
        .clk   (clk),
        .rst   (rst),
        .wr_en (op == OP_LINK_WRITE),
        .slot  (slot),
        .wdata (req_wdata),
        .rdata (link_rd)
    );

    assign xirr_word = {cppr, irq_out ? pend.src : SRC_W'(0)};

    always_comb begin
        case (op)
            OP_POLL_WORD, OP_ACCEPT: rd_mux = xirr_word;
            OP_PRIO_READ:            rd_mux = WORD_W'(cppr);
            OP_IPI_READ:             rd_mux = WORD_W'(ipi_prio);
            OP_LINK_READ:            rd_mux = link_rd;
            OP_BAD:                  rd_mux = '1;
            default:                 rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            bad_access <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_rdata  <= rd_mux;
            bad_access <= (op == OP_BAD);
        end
    end

endmodule

// File: rtl/ipr_top_chk.sv
module ipr_top_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [11:0] req_addr,
    input logic [2:0]  req_size,
    input logic [23:0] wdata_lo,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        bad_access,
    input logic        src_valid,
    input logic        irq_out,
    input logic        eoi_valid,
    input logic [23:0] eoi_source
);
    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R9
    bad_has_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        bad_access |-> rsp_valid);

    // R9
    bad_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (bad_access && !$past(req_write)) |-> (rsp_rdata == 32'hFFFF_FFFF));

    // R6
    eoi_origin_chk: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> ($past(req_valid && req_write && req_size == 3'd4
                             && req_addr[11:2] == 10'd1)
                       && eoi_source == $past(wdata_lo)));

    // R5
    prio_zero_masks_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size == 3'd1 && req_addr[11:2] == 10'd1
         && req_addr[1:0] == 2'b00 && wdata_lo[7:0] == 8'h00) |=> !irq_out);

    // R4
    accept_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 3'd4 && req_addr[11:2] == 10'd1
         && !src_valid) |=> !irq_out);

    // R2
    poll_keeps_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr[11:2] == 10'd0 && !src_valid)
        |=> (irq_out == $past(irq_out)));

endmodule

bind ipr_top ipr_top_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .wdata_lo   (req_wdata[23:0]),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .bad_access (bad_access),
    .src_valid  (src_valid),
    .irq_out    (irq_out),
    .eoi_valid  (eoi_valid),
    .eoi_source (eoi_source)
);

// File: tb/ipr_top_tb.sv
module ipr_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        bad_access;
    logic        src_valid = 1'b0;
    logic [23:0] src_num = '0;
    logic [7:0]  src_prio = '0;
    logic        irq_out;
    logic        eoi_valid;
    logic [23:0] eoi_source;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] rdata;
        bit          is_read;
        bit          bad;
        bit          eoi;
        logic [23:0] eoi_src;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ipr_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .bad_access (bad_access),
        .src_valid  (src_valid),
        .src_num    (src_num),
        .src_prio   (src_prio),
        .irq_out    (irq_out),
        .eoi_valid  (eoi_valid),
        .eoi_source (eoi_source)
    );

    // Monitor: pops one expected item per response, checks stray end-of-interrupt pulses.
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R11 unexpected response rdata=%h", rsp_rdata);
                end else begin
                    exp_t e;
                    bit ok;
                    e = exp_q.pop_front();
                    checks++;
                    ok = (bad_access == e.bad) && (eoi_valid == e.eoi)
                         && (!e.is_read || rsp_rdata == e.rdata)
                         && (!e.eoi || eoi_source == e.eoi_src);
                    if (!ok) begin
                        fails++;
                        $display("FAIL %s: rdata=%h bad=%0b eoi=%0b/%h expected rdata=%h bad=%0b eoi=%0b/%h",
                                 e.tag, rsp_rdata, bad_access, eoi_valid, eoi_source,
                                 e.rdata, e.bad, e.eoi, e.eoi_src);
                    end
                end
            end else if (eoi_valid) begin
                checks++; fails++;
                $display("FAIL R6 eoi pulse without response src=%h expected none", eoi_source);
            end
        end
    end

    // Driver: queue the expectation, then drive one request cycle.
    task automatic access(input bit wr, input logic [11:0] addr, input logic [2:0] size,
                          input logic [31:0] wd, input logic [31:0] exp_rd, input bit bad,
                          input bit eoi, input string tag);
        exp_t e;
        e.rdata = exp_rd; e.is_read = !wr; e.bad = bad;
        e.eoi = eoi; e.eoi_src = wd[23:0]; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = size; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] addr, input logic [2:0] size,
                      input logic [31:0] exp_rd, input bit bad, input string tag);
        access(1'b0, addr, size, 32'h0, exp_rd, bad, 1'b0, tag);
    endtask

    task automatic wr(input logic [11:0] addr, input logic [2:0] size,
                      input logic [31:0] wd, input bit bad, input bit eoi, input string tag);
        access(1'b1, addr, size, wd, 32'h0, bad, eoi, tag);
    endtask

    task automatic present(input logic [23:0] num, input logic [7:0] prio);
        @(negedge clk);
        src_valid = 1'b1; src_num = num; src_prio = prio;
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        checks++;
        if (irq_out !== exp) begin
            fails++;
            $display("FAIL %s: irq_out=%0b expected %0b", tag, irq_out, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_irq(1'b0, "R1 irq after reset");
        checks++;
        if (eoi_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 eoi_valid=%0b expected 0", eoi_valid);
        end

        // R1 / R2 / R3 reset contents
        rd(12'h000, 3'd4, 32'h0000_0000, 0, "R2 poll after reset");
        rd(12'h004, 3'd1, 32'h0000_0000, 0, "R1 R3 priority after reset");
        rd(12'h00C, 3'd1, 32'h0000_00FF, 0, "R1 ipi priority after reset");
        rd(12'h010, 3'd4, 32'h0000_0000, 0, "R1 link after reset");

        // R5 set priority, R3 byte read at 0x0
        wr(12'h004, 3'd1, 32'h0000_00FF, 0, 0, "R5 set priority");
        rd(12'h000, 3'd1, 32'h0000_00FF, 0, "R3 byte poll");

        // R8 link storage
        wr(12'h010, 3'd4, 32'hA5A5_0001, 0, 0, "R8 link0 write");
        wr(12'h014, 3'd4, 32'h5A5A_0002, 0, 0, "R8 link1 write");
        wr(12'h018, 3'd4, 32'h1234_5678, 0, 0, "R8 link2 write");
        rd(12'h010, 3'd4, 32'hA5A5_0001, 0, "R8 link0 read");
        rd(12'h014, 3'd4, 32'h5A5A_0002, 0, "R8 link1 read");
        rd(12'h018, 3'd4, 32'h1234_5678, 0, "R8 link2 read");

        // R9 illegal accesses
        rd(12'h000, 3'd2, 32'hFFFF_FFFF, 1, "R9 half read poll");
        rd(12'h010, 3'd1, 32'hFFFF_FFFF, 1, "R9 byte read link");
        rd(12'h005, 3'd1, 32'hFFFF_FFFF, 1, "R9 byte off lane0");
        rd(12'h008, 3'd4, 32'hFFFF_FFFF, 1, "R9 unmapped 0x8");
        rd(12'h01C, 3'd4, 32'hFFFF_FFFF, 1, "R9 unmapped after links");
        wr(12'h014, 3'd2, 32'h0000_0000, 1, 0, "R9 half write link");
        rd(12'h014, 3'd4, 32'h5A5A_0002, 0, "R9 link unchanged");
        wr(12'h005, 3'd1, 32'h0000_0000, 1, 0, "R9 byte write off lane0");
        rd(12'h004, 3'd1, 32'h0000_00FF, 0, "R9 priority unchanged");
        wr(12'h000, 3'd4, 32'h0000_0000, 1, 0, "R9 write to poll");

        // R10 offers and R2 poll
        chk_irq(1'b0, "R10 idle");
        present(24'h000123, 8'h40);
        chk_irq(1'b1, "R10 offer kept");
        rd(12'h000, 3'd4, 32'hFF00_0123, 0, "R2 poll pending");
        chk_irq(1'b1, "R2 poll no side effect");
        present(24'h000077, 8'h50);
        rd(12'h000, 3'd4, 32'hFF00_0123, 0, "R10 less favoured dropped");
        present(24'h000099, 8'h30);
        rd(12'h000, 3'd4, 32'hFF00_0099, 0, "R10 more favoured replaces");

        // R4 accept
        rd(12'h004, 3'd4, 32'hFF00_0099, 0, "R4 accept");
        chk_irq(1'b0, "R4 irq dropped");
        rd(12'h004, 3'd1, 32'h0000_0030, 0, "R4 priority raised");
        rd(12'h004, 3'd4, 32'h3000_0000, 0, "R4 accept with nothing");
        present(24'h000055, 8'h30);
        chk_irq(1'b0, "R10 equal priority dropped");

        // R6 end of interrupt
        wr(12'h004, 3'd4, 32'hFF00_0099, 0, 1, "R6 eoi");
        rd(12'h004, 3'd1, 32'h0000_00FF, 0, "R6 priority from eoi word");

        // R7 IPI
        wr(12'h00C, 3'd1, 32'h0000_0020, 0, 0, "R7 ipi write");
        chk_irq(1'b1, "R7 ipi raises irq");
        rd(12'h000, 3'd4, 32'hFF00_0002, 0, "R7 ipi source");
        rd(12'h00C, 3'd1, 32'h0000_0020, 0, "R7 ipi readback");
        rd(12'h00C, 3'd4, 32'hFFFF_FFFF, 1, "R7 ipi word read illegal");

        // R5 masking keeps pending
        wr(12'h004, 3'd1, 32'h0000_0010, 0, 0, "R5 mask");
        chk_irq(1'b0, "R5 masked");
        rd(12'h000, 3'd4, 32'h1000_0000, 0, "R5 masked poll");
        wr(12'h004, 3'd1, 32'h0000_00FF, 0, 0, "R5 unmask");
        chk_irq(1'b1, "R5 unmasked");
        rd(12'h004, 3'd4, 32'hFF00_0002, 0, "R4 accept ipi");
        wr(12'h004, 3'd2, 32'hFF00_0002, 1, 0, "R9 half eoi ignored");
        rd(12'h004, 3'd1, 32'h0000_0020, 0, "R9 priority kept");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R11 missing responses: %0d left expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule